// File: doc/BRIEF.md
# Output FIFO Priming Sequencer

This block brings a PHY output path out of reset. It fills a command-word FIFO and an output FIFO before real traffic starts, so that the reader behind the output FIFO never sees an empty cycle. While it primes, it pushes 32-bit control words that carry a long fetch delay and a non-data opcode. It also writes no-operation entries into the output FIFO until that FIFO reports full.

Once the output FIFO is full, every write to it stops. The sequencer waits for the reader to start draining, which shows up as the full flag falling. It then waits a fixed gap and enters its run phase. In the run phase it pushes data-opcode control words and forwards the user entry on every cycle, and it raises a ready flag. From then on the output FIFO is written on every cycle, in step with the reader. The control-word strobe always follows that FIFO's full flag.

Top module: `ofifo_prime_seq`

## Requirements
- R1: While reset is high, and in the first cycle after reset is released, `cw_wr`, `of_wr` and `ready` are all low.
- R2: `cw_word` bits [31:30] are 2'b01 and bits [29:25] are 5'b11111. Every bit from 24 down to 3 is zero, which keeps both offset fields at zero.
- R3: `cw_word[2:0]` is 3'b100 (non-data) in every cycle before `ready` rises, and 3'b001 (data) while `ready` is high. The full word is therefore 32'h7E000004 before `ready` and 32'h7E000001 while `ready` is high.
- R4: From the second cycle after reset release, `cw_wr` is high in exactly the cycles in which `cw_full` is low.
- R5: From the second cycle after reset release, `of_wr` is high in every cycle until the first cycle in which `of_full` is high. Every one of these writes carries the all-zero no-operation entry on `of_entry`.
- R6: `of_wr` is low from the first cycle in which `of_full` is high. It stays low through the cycle in which the flag falls and through the cycle that follows.
- R7: If `of_full` is first seen low again in cycle t, then `of_wr` and `ready` both rise in cycle t+2.
- R8: Once `ready` is high, `of_wr` is high on every cycle whatever `of_full` shows, and `of_entry` equals `usr_data` in the same cycle.
- R9: Once `ready` rises it stays high until reset.
- R10: Against an output FIFO that flags full after nine stored entries, priming writes exactly nine no-operation entries.
- R11: Asserting reset at any point, including during the run phase, restarts the whole priming sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cw_full | input | 1 | Control-word FIFO full flag |
| of_full | input | 1 | Output FIFO full flag |
| usr_data | input | ENTRY_W | User entry forwarded during run phase |
| cw_wr | output | 1 | Control-word FIFO write strobe |
| cw_word | output | 32 | Control word |
| of_wr | output | 1 | Output FIFO write enable |
| of_entry | output | ENTRY_W | Output FIFO entry |
| ready | output | 1 | High in the run phase |

## Verification
The hardest situation to reach is the handover from hold to run. Writes must stay off through the falling edge of full and the one cycle after it, then resume for good. That edge only appears when a real FIFO fills and a reader starts draining.

The bench therefore models a nine-deep FIFO driven by the block's own writes. It sweeps how many cycles the reader waits after full before it starts. It derives the expected restart cycle from the observed fall of the flag, while the control-word full flag runs through several patterns at the same time.

// File: rtl/ofp_pkg.sv
package ofp_pkg;
  typedef enum logic [2:0] {
    PH_RESET = 3'd0,
    PH_PRIME = 3'd1,
    PH_HOLD  = 3'd2,
    PH_GAP   = 3'd3,
    PH_RUN   = 3'd4
  } phase_e;

  localparam int CW_W    = 32;
  localparam int TAG_LSB = 30;
  localparam int DLY_LSB = 25;
  localparam int DLY_W   = 5;
  localparam int OP_W    = 3;
  localparam logic [1:0]      CW_TAG     = 2'b01;
  localparam logic [OP_W-1:0] OP_NONDATA = 3'b100;
  localparam logic [OP_W-1:0] OP_DATA    = 3'b001;
endpackage

// File: rtl/ofp_phase_fsm.sv
module ofp_phase_fsm
  import ofp_pkg::*;
#(
  parameter int GAP = 2
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   of_full,
  output phase_e phase
);
  localparam int GAP_W = (GAP < 2) ? 1 : $clog2(GAP + 1);

  logic [GAP_W-1:0] gap_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_RESET;
      gap_cnt <= '0;
    end else begin
      case (phase)
        PH_RESET: phase <= PH_PRIME;
        PH_PRIME: if (of_full) phase <= PH_HOLD;
        PH_HOLD: begin
          if (!of_full) begin
            if (GAP <= 1) begin
              phase <= PH_RUN;
            end else begin
              phase   <= PH_GAP;
              gap_cnt <= GAP_W'(GAP - 1);
            end
          end
        end
        PH_GAP: begin
          if (gap_cnt <= GAP_W'(1)) phase <= PH_RUN;
          else gap_cnt <= gap_cnt - 1'b1;
        end
        PH_RUN:  phase <= PH_RUN;
        default: phase <= PH_RESET;
      endcase
    end
  end

  // R9: run phase is left only through reset
  assert_run_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    phase == PH_RUN |=> phase == PH_RUN);

  // R6: hold persists while the flag stays high
  assert_hold_while_full_R6: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_HOLD && of_full) |=> phase == PH_HOLD);
endmodule

// File: rtl/ofp_word_fmt.sv
module ofp_word_fmt
  import ofp_pkg::*;
#(
  parameter logic [DLY_W-1:0] DELAY_VAL = '1
) (
  input  phase_e          phase,
  output logic [CW_W-1:0] cw_word
);
  always_comb begin
    cw_word = '0;
    cw_word[TAG_LSB +: 2]     = CW_TAG;
    cw_word[DLY_LSB +: DLY_W] = DELAY_VAL;
    cw_word[OP_W-1:0]         = (phase == PH_RUN) ? OP_DATA : OP_NONDATA;
  end
endmodule

// File: rtl/ofp_out_writer.sv
module ofp_out_writer
  import ofp_pkg::*;
#(
  parameter int                 ENTRY_W   = 16,
  parameter logic [ENTRY_W-1:0] NOP_ENTRY = '0
) (
  input  phase_e             phase,
  input  logic               of_full,
  input  logic [ENTRY_W-1:0] usr_data,
  output logic               of_wr,
  output logic [ENTRY_W-1:0] of_entry
);
  always_comb begin
    of_wr    = (phase == PH_RUN) || (phase == PH_PRIME && !of_full);
    of_entry = (phase == PH_RUN) ? usr_data : NOP_ENTRY;
  end
endmodule

// File: rtl/ofifo_prime_seq.sv
module ofifo_prime_seq
  import ofp_pkg::*;
#(
  parameter int                 ENTRY_W   = 16,
  parameter int                 GAP       = 2,
  parameter logic [DLY_W-1:0]   DELAY_VAL = '1,
  parameter logic [ENTRY_W-1:0] NOP_ENTRY = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cw_full,
  input  logic               of_full,
  input  logic [ENTRY_W-1:0] usr_data,
  output logic               cw_wr,
  output logic [CW_W-1:0]    cw_word,
  output logic               of_wr,
  output logic [ENTRY_W-1:0] of_entry,
  output logic               ready
);
  phase_e phase;

  ofp_phase_fsm #(.GAP(GAP)) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .of_full (of_full),
    .phase   (phase)
  );

  ofp_word_fmt #(.DELAY_VAL(DELAY_VAL)) u_word (
    .phase   (phase),
    .cw_word (cw_word)
  );

  ofp_out_writer #(.ENTRY_W(ENTRY_W), .NOP_ENTRY(NOP_ENTRY)) u_wr (
    .phase    (phase),
    .of_full  (of_full),
    .usr_data (usr_data),
    .of_wr    (of_wr),
    .of_entry (of_entry)
  );

  assign cw_wr = (phase != PH_RESET) && !cw_full;
  assign ready = (phase == PH_RUN);

  assert_no_cw_push_full_R4: assert property (@(posedge clk) disable iff (rst)
    cw_full |-> !cw_wr);

  assert_no_prime_write_full_R6: assert property (@(posedge clk) disable iff (rst)
    (of_full && !ready) |-> !of_wr);

  assert_run_data_op_R3: assert property (@(posedge clk) disable iff (rst)
    ready |-> cw_word[OP_W-1:0] == OP_DATA);

  assert_run_writes_R8: assert property (@(posedge clk) disable iff (rst)
    ready |-> of_wr);

  assert_prime_nop_R5: assert property (@(posedge clk) disable iff (rst)
    (of_wr && !ready) |-> of_entry == NOP_ENTRY);
endmodule

// File: tb/sim_ofifo_prime_seq.sv
module sim_ofifo_prime_seq;
  localparam int ENTRY_W = 16;
  localparam int DEPTH   = 9;
  localparam int CYC     = 60;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cw_full = 1'b0;
  logic of_full;
  logic rd_go = 1'b0;
  logic [ENTRY_W-1:0] usr_data = '0;
  logic cw_wr, of_wr, ready;
  logic [31:0] cw_word;
  logic [ENTRY_W-1:0] of_entry;
  int cnt_q;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ofifo_prime_seq #(.ENTRY_W(ENTRY_W)) u0 (
    .clk(clk), .rst(rst), .cw_full(cw_full), .of_full(of_full),
    .usr_data(usr_data), .cw_wr(cw_wr), .cw_word(cw_word),
    .of_wr(of_wr), .of_entry(of_entry), .ready(ready)
  );

  // nine-deep output FIFO occupancy model
  assign of_full = (cnt_q == DEPTH);
  always @(posedge clk) begin
    if (rst) cnt_q <= 0;
    else cnt_q <= cnt_q + ((of_wr && !of_full) ? 1 : 0)
                        - ((rd_go && cnt_q != 0) ? 1 : 0);
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic cwf_pat(input int n, input int pat);
    case (pat)
      0:       return 1'b0;
      1:       return (n % 3) == 1;
      default: return ((n * 7 + 3) % 5) < 2;
    endcase
  endfunction

  task automatic run_scenario(input int lag, input int pat);
    bit rise_set = 0, fall_set = 0;
    int t_rise = 0, t_fall = 0, prim = 0;
    logic exp_wr, exp_rdy;
    rst = 1'b1;           // R11: reset applied on top of prior run
    rd_go = 1'b0;
    cw_full = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 cw_wr in reset", {31'd0, cw_wr}, 32'd0);
    chk("R1 of_wr in reset", {31'd0, of_wr}, 32'd0);
    chk("R1 ready in reset", {31'd0, ready}, 32'd0);
    @(posedge clk);
    #1 rst = 1'b0;
    for (int n = 0; n < CYC; n++) begin
      cw_full  = cwf_pat(n, pat);
      usr_data = ENTRY_W'(16'hA500 + n + pat * 64 + lag * 8);
      @(negedge clk);
      if (!rise_set && of_full) begin rise_set = 1; t_rise = n; end
      if (rise_set && !fall_set && !of_full && n > t_rise) begin fall_set = 1; t_fall = n; end
      exp_rdy = fall_set && (n >= t_fall + 2);
      exp_wr  = (n >= 1 && !rise_set) || exp_rdy;
      chk(n == 0 ? "R1 of_wr first cycle" : "R5/R6/R7/R8 of_wr", {31'd0, of_wr}, {31'd0, exp_wr});
      chk("R7/R9 ready", {31'd0, ready}, {31'd0, exp_rdy});
      chk("R4 cw_wr", {31'd0, cw_wr}, {31'd0, (n >= 1) && !cw_full});
      chk("R2/R3 cw_word", cw_word, exp_rdy ? 32'h7E000001 : 32'h7E000004);
      if (of_wr && exp_rdy) chk("R8 of_entry", {16'd0, of_entry}, {16'd0, usr_data});
      if (of_wr && !exp_rdy) begin
        prim++;
        chk("R5 nop entry", {16'd0, of_entry}, 32'd0);
      end
      @(posedge clk);
      #1;
      if (rise_set && n >= t_rise + lag) rd_go = 1'b1;
    end
    chk("R10 primed entries", prim, DEPTH);
    chk("R7 full fell", {31'd0, fall_set}, 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int lag = 0; lag < 6; lag++)
      for (int pat = 0; pat < 3; pat++)
        run_scenario(lag, pat);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule